// File: doc/BRIEF.md
# Interpolating Direct Digital Sine Synthesizer

This block generates a digital sine wave whose frequency is set by a programmable tuning word. A wide phase register adds the tuning word on every clock and wraps around modulo its full range. The top address bits of that phase select a sine table entry. The next bits down form an interpolation fraction that blends each entry with its neighbour, so the amplitude is much finer than the table spacing alone would give. The output frequency is Fclk times the tuning word, divided by 2 to the power of the phase width.

The part of the phase below the table address is dropped before the table lookup. This dropped part, the truncation remainder, is brought out on an observation port, aligned with the sample it belongs to. It rises as a sawtooth and falls back whenever it carries into the address field. An optional pseudo-random dither can be added below the address LSB before truncation. The dither breaks up the periodicity of that sawtooth. With dither off, the output is fully deterministic.

A parameter selects the table variant: a quarter-wave table folded by symmetry, or a full-wave table. Converter drive and analog filtering belong to other blocks.

Top module: `dds_interp_sine`

## Requirements
- R1: With dither off, the phase register P starts at 0 and advances by the tuning word, modulo 2^ACC_W, on every clock. The sample that appears three clocks after a phase value is y = s[k] + floor(((s[k+1] - s[k]) * f) / 2^FRAC_W), where k = P[ACC_W-1 -: ADDR_W], f = P[ACC_W-ADDR_W-1 -: FRAC_W], and s[i] = floor((2^(OUT_W-1)-1) * sin(2*pi*i/2^ADDR_W) + 0.5).
- R2: A tuning word captured with tw_load at one clock edge is first added at the following edge. Loading it does not disturb the current phase.
- R3: phase_clr sets the phase to 0 at the edge where it is sampled, taking priority over the add. Three clocks later the output is 0 and phase_err is 0.
- R4: When k is the last table index, the interpolation neighbour k+1 wraps to index 0.
- R5: phase_err equals P[ACC_W-ADDR_W-1:0] of the phase value that produced the sample on the same cycle (dither off).
- R6: With dither off and the tuning word's low ACC_W-ADDR_W bits all zero, phase_err stays constant.
- R7: With dither_en high, a value below one address LSB, taken from a maximal-length LFSR that is never zero, is added to the phase before truncation. Each sample then lies within the range of s[k], s[k+1] and s[k+2]. With a zero tuning word, phase_err changes over time.
- R8: During reset, sample_out, sample_vld and phase_err are 0. sample_vld goes high on the third edge after reset is released and stays high.
- R9: The quarter-wave and full-wave table variants produce identical samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tw_load | input | 1 | Capture tw_in as the new tuning word |
| tw_in | input | ACC_W | Tuning word value |
| phase_clr | input | 1 | Force the phase register to zero |
| dither_en | input | 1 | Add pseudo-random dither below the address LSB |
| sample_out | output | OUT_W | Signed interpolated sine sample |
| sample_vld | output | 1 | Pipeline is filled and sample_out is meaningful |
| phase_err | output | ACC_W-ADDR_W | Truncation remainder aligned with sample_out |

## Verification
The assertions assume the control inputs are clean levels sampled at the clock edge. They also assume the two table entries fed to the interpolator are adjacent, so their blend always lies between them and fits the output width. The stimulus keeps tw_in, tw_load, phase_clr and dither_en changing only on the falling edge. It draws random tuning words across the full phase width and adds directed cases: a word with empty low bits, the last-index wrap, and clears issued in the middle of a stream. In dither mode the exact sample cannot be predicted from outside, so those cycles are checked against an amplitude window instead of an exact value.

// File: rtl/dds_pkg.sv
package dds_pkg;
   localparam real TWO_PI = 6.283185307179586;

   // signed table code for index idx of a full cycle split into depth_full steps
   function automatic int sine_code(int idx, int depth_full, int out_w);
      real amp;
      real ang;
      amp = real'((1 << (out_w - 1)) - 1);
      ang = TWO_PI * real'(idx) / real'(depth_full);
      return $rtoi($floor(amp * $sin(ang) + 0.5));
   endfunction
endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
   parameter int ACC_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tw_load,
   input  logic [ACC_W-1:0] tw_in,
   input  logic             phase_clr,
   output logic [ACC_W-1:0] acc_q
);
   logic [ACC_W-1:0] tw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tw_q  <= '0;
         acc_q <= '0;
      end else begin
         if (tw_load) tw_q <= tw_in;
         if (phase_clr) acc_q <= '0;
         else           acc_q <= acc_q + tw_q;
      end
   end

   // R3
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_clr |=> (acc_q == '0));

   // R2
   tw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tw_load |=> $stable(tw_q));
endmodule

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr #(
   parameter int              LFSR_W = 16,
   parameter logic [LFSR_W-1:0] POLY = 16'hB400,
   parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [LFSR_W-1:0] lfsr_q
);
   generate
      if (SEED == '0) begin : g_bad_seed
         $error("dither LFSR seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        lfsr_q <= SEED;
      else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ POLY;
      else               lfsr_q <= lfsr_q >> 1;
   end

   // R7
   lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
   parameter int ADDR_W  = 10,
   parameter int OUT_W   = 18,
   parameter bit QUARTER = 1'b1
) (
   input  logic [ADDR_W-1:0]        addr,
   output logic signed [OUT_W-1:0]  value
);
   localparam int FULL = 1 << ADDR_W;

   generate
      if (QUARTER) begin : g_quarter
         localparam int QW    = ADDR_W - 2;
         localparam int QN    = 1 << QW;
         localparam int DEPTH = QN + 1;
         logic signed [OUT_W-1:0] tab [0:DEPTH-1];
         for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            localparam int CODE = dds_pkg::sine_code(i, FULL, OUT_W);
            assign tab[i] = OUT_W'(CODE);
         end
         logic [1:0]              quad;
         logic [QW:0]             idx;
         logic signed [OUT_W-1:0] mag;
         always_comb begin
            quad = addr[ADDR_W-1 -: 2];
            if (quad[0]) idx = (QW+1)'(QN) - {1'b0, addr[QW-1:0]};
            else         idx = {1'b0, addr[QW-1:0]};
            mag   = tab[idx];
            value = quad[1] ? -mag : mag;
         end
      end else begin : g_full
         logic signed [OUT_W-1:0] tab [0:FULL-1];
         for (genvar i = 0; i < FULL; i++) begin : g_ent
            localparam int CODE = dds_pkg::sine_code(i, FULL, OUT_W);
            assign tab[i] = OUT_W'(CODE);
         end
         assign value = tab[addr];
      end
   endgenerate
endmodule

// File: rtl/dds_interp.sv
module dds_interp #(
   parameter int OUT_W  = 18,
   parameter int FRAC_W = 8,
   parameter int ERR_W  = 38
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic signed [OUT_W-1:0] s0,
   input  logic signed [OUT_W-1:0] s1,
   input  logic [FRAC_W-1:0]       frac,
   input  logic [ERR_W-1:0]        err_in,
   output logic signed [OUT_W-1:0] y_q,
   output logic                    vld_q,
   output logic [ERR_W-1:0]        err_q
);
   localparam int PW = OUT_W + FRAC_W + 2;

   logic signed [OUT_W:0]   diff;
   logic signed [PW-1:0]    prod;
   logic signed [PW-1:0]    step;
   logic signed [PW-1:0]    sum_w;

   always_comb begin
      diff  = (OUT_W+1)'(s1) - (OUT_W+1)'(s0);
      prod  = diff * $signed({1'b0, frac});
      step  = prod >>> FRAC_W;
      sum_w = step + PW'(s0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q   <= '0;
         vld_q <= 1'b0;
         err_q <= '0;
      end else begin
         y_q   <= sum_w[OUT_W-1:0];
         vld_q <= in_vld;
         err_q <= err_in;
      end
   end

   // R4
   sum_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_w[PW-1:OUT_W-1] == '0) || (sum_w[PW-1:OUT_W-1] == '1));

   // R4
   interp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> ((y_q >= $past(s0) && y_q <= $past(s1)) ||
                  (y_q <= $past(s0) && y_q >= $past(s1))));
endmodule

// File: rtl/dds_interp_sine.sv
module dds_interp_sine #(
   parameter int              ACC_W   = 48,
   parameter int              ADDR_W  = 10,
   parameter int              FRAC_W  = 8,
   parameter int              OUT_W   = 18,
   parameter bit              QUARTER = 1'b1,
   parameter int              DITH_W  = 16,
   parameter logic [DITH_W-1:0] DITH_POLY = 16'hB400,
   parameter logic [DITH_W-1:0] DITH_SEED = 16'hACE1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tw_load,
   input  logic [ACC_W-1:0]              tw_in,
   input  logic                          phase_clr,
   input  logic                          dither_en,
   output logic signed [OUT_W-1:0]       sample_out,
   output logic                          sample_vld,
   output logic [ACC_W-ADDR_W-1:0]       phase_err
);
   localparam int R_W = ACC_W - ADDR_W;

   generate
      if (ADDR_W < 3)                 begin : g_e0 $error("ADDR_W too small"); end
      if (FRAC_W < 1)                 begin : g_e1 $error("FRAC_W must be positive"); end
      if (ADDR_W + FRAC_W > ACC_W)    begin : g_e2 $error("address and fraction exceed phase"); end
      if (DITH_W > R_W || DITH_W < 1) begin : g_e3 $error("dither width out of range"); end
      if (OUT_W < 4 || OUT_W > 31)    begin : g_e4 $error("OUT_W out of range"); end
   endgenerate

   // phase accumulation
   logic [ACC_W-1:0] acc_q;
   dds_phase_accum #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .tw_load(tw_load), .tw_in(tw_in),
      .phase_clr(phase_clr), .acc_q(acc_q));

   logic [DITH_W-1:0] lfsr_q;
   dds_dither_lfsr #(.LFSR_W(DITH_W), .POLY(DITH_POLY), .SEED(DITH_SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .lfsr_q(lfsr_q));

   // stage 1: dither and truncation
   logic [ACC_W-1:0] dith_ext;
   logic [ACC_W-1:0] phase_d;
   assign dith_ext = dither_en ? (ACC_W'(lfsr_q) << (R_W - DITH_W)) : '0;
   assign phase_d  = acc_q + dith_ext;

   logic [ADDR_W-1:0] st1_addr;
   logic [FRAC_W-1:0] st1_frac;
   logic [R_W-1:0]    st1_err;
   logic              st1_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st1_addr <= '0;
         st1_frac <= '0;
         st1_err  <= '0;
         st1_vld  <= 1'b0;
      end else begin
         st1_addr <= phase_d[ACC_W-1 -: ADDR_W];
         st1_frac <= phase_d[R_W-1 -: FRAC_W];
         st1_err  <= phase_d[R_W-1:0];
         st1_vld  <= 1'b1;
      end
   end

   // stage 2: two table reads, neighbour index wraps at table end
   logic [ADDR_W-1:0]       rd_addr [2];
   logic signed [OUT_W-1:0] rd_val  [2];
   assign rd_addr[0] = st1_addr;
   assign rd_addr[1] = st1_addr + 1'b1;

   generate
      for (genvar p = 0; p < 2; p++) begin : g_port
         dds_sine_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .QUARTER(QUARTER)) u_rom (
            .addr(rd_addr[p]), .value(rd_val[p]));
      end
   endgenerate

   logic signed [OUT_W-1:0] st2_s0, st2_s1;
   logic [FRAC_W-1:0]       st2_frac;
   logic [R_W-1:0]          st2_err;
   logic                    st2_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st2_s0   <= '0;
         st2_s1   <= '0;
         st2_frac <= '0;
         st2_err  <= '0;
         st2_vld  <= 1'b0;
      end else begin
         st2_s0   <= rd_val[0];
         st2_s1   <= rd_val[1];
         st2_frac <= st1_frac;
         st2_err  <= st1_err;
         st2_vld  <= st1_vld;
      end
   end

   // stage 3: linear interpolation
   dds_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W), .ERR_W(R_W)) u_interp (
      .clk(clk), .rst_n(rst_n), .in_vld(st2_vld), .s0(st2_s0), .s1(st2_s1),
      .frac(st2_frac), .err_in(st2_err), .y_q(sample_out), .vld_q(sample_vld),
      .err_q(phase_err));

   // R8
   vld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> sample_vld);
endmodule

// File: tb/test_dds_interp_sine.sv
`timescale 1ns/1ps
module test_dds_interp_sine;
   localparam int AW = 48, KW = 10, FW = 8, OW = 18, RW = AW - KW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tw_load = 1'b0, phase_clr = 1'b0, dither_en = 1'b0;
   logic [AW-1:0] tw_in = '0;
   logic signed [OW-1:0] q_out, f_out;
   logic q_vld, f_vld;
   logic [RW-1:0] q_err, f_err;

   always #2.5 clk = ~clk;

   dds_interp_sine i_dds_interp_sine (
      .clk(clk), .rst_n(rst_n), .tw_load(tw_load), .tw_in(tw_in),
      .phase_clr(phase_clr), .dither_en(dither_en),
      .sample_out(q_out), .sample_vld(q_vld), .phase_err(q_err));

   dds_interp_sine #(.QUARTER(1'b0)) i_dds_interp_sine_full (
      .clk(clk), .rst_n(rst_n), .tw_load(tw_load), .tw_in(tw_in),
      .phase_clr(phase_clr), .dither_en(dither_en),
      .sample_out(f_out), .sample_vld(f_vld), .phase_err(f_err));

   int n_cmp = 0, n_bad = 0, nedge = 0;
   bit done = 1'b0;
   string tag = "R1";
   bit [AW-1:0] m_acc, m_tw;
   bit [AW-1:0] ha [4];
   bit hd [4];
   bit track_err = 1'b0;
   bit [RW-1:0] last_err;
   int err_changes = 0;

   function automatic longint sv(longint k);
      real amp;
      amp = real'((1 << (OW - 1)) - 1);
      return longint'($rtoi($floor(amp * $sin(6.283185307179586 * real'(k % 1024) / 1024.0) + 0.5)));
   endfunction

   function automatic longint model(bit [AW-1:0] ph);
      longint k, f, s0, s1, d;
      k  = longint'(ph >> RW) & 1023;
      f  = longint'(ph >> (RW - FW)) & 255;
      s0 = sv(k);
      s1 = sv((k + 1) % 1024);
      d  = (s1 - s0) * f;
      return s0 + (d >>> FW);
   endfunction

   task automatic chk(bit ok, string t, longint act, longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
      end
   endtask

   task automatic check_out();
      longint e, k, lo, hi, v;
      bit ev;
      ev = (nedge >= 3);
      chk(q_vld == ev, "R8", longint'(q_vld), longint'(ev));
      if (!ev) begin
         chk(q_out == 0, "R8", longint'(q_out), 0);
      end else begin
         chk(q_out == f_out, "R9", longint'(f_out), longint'(q_out));
         if (!hd[2]) begin
            e = model(ha[3]);
            chk(longint'(q_out) == e, tag, longint'(q_out), e);
            chk(q_err == ha[3][RW-1:0], (tag == "R6") ? "R6" : "R5",
                longint'(q_err), longint'(ha[3][RW-1:0]));
         end else begin
            k  = longint'(ha[3] >> RW) & 1023;
            lo = sv(k); hi = lo;
            for (int j = 1; j < 3; j++) begin
               v = sv((k + j) % 1024);
               if (v < lo) lo = v;
               if (v > hi) hi = v;
            end
            chk(longint'(q_out) >= lo && longint'(q_out) <= hi, "R7", longint'(q_out), lo);
            if (track_err) begin
               if (q_err != last_err) err_changes++;
               last_err = q_err;
            end
         end
      end
   endtask

   task automatic step(bit ld, bit [AW-1:0] w, bit clr, bit dith);
      tw_load = ld; tw_in = w; phase_clr = clr; dither_en = dith;
      @(posedge clk);
      for (int i = 3; i > 0; i--) begin
         ha[i] = ha[i-1];
         hd[i] = hd[i-1];
      end
      ha[0] = clr ? '0 : m_acc + m_tw;
      m_acc = ha[0];
      if (ld) m_tw = w;
      hd[0] = dith;
      nedge++;
      @(negedge clk);
      check_out();
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      bit [RW-1:0] first_err;
      bit [AW-1:0] w;
      void'($urandom(32'd20141209));
      for (int i = 0; i < 4; i++) begin ha[i] = '0; hd[i] = 1'b0; end
      m_acc = '0; m_tw = '0;
      repeat (4) @(negedge clk);
      // R8: reset state
      chk(q_out == 0 && q_vld == 0, "R8", longint'(q_out), 0);
      chk(q_err == 0, "R8", longint'(q_err), 0);
      rst_n = 1'b1;

      // R3: clear then exact step of one table entry
      tag = "R3";
      step(1'b1, AW'(1) << RW, 1'b1, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0);
      chk(q_out == 0 && q_err == 0, "R3", longint'(q_out), 0);

      // R6: low bits of tuning word zero, error constant
      tag = "R6";
      step(1'b1, (AW'(37) << RW), 1'b1, 1'b0);
      repeat (4) step(1'b0, '0, 1'b0, 1'b0);
      first_err = q_err;
      for (int i = 0; i < 30; i++) begin
         step(1'b0, '0, 1'b0, 1'b0);
         chk(q_err == first_err, "R6", longint'(q_err), longint'(first_err));
      end

      // R4: last table index, neighbour wraps to 0
      tag = "R4";
      step(1'b1, AW'(0) - (AW'(1) << 36), 1'b1, 1'b0);
      repeat (12) step(1'b0, '0, 1'b0, 1'b0);

      // R2: mid-stream loads without phase reset
      tag = "R2";
      for (int i = 0; i < 40; i++) begin
         w = {$urandom, $urandom};
         step((i % 5) == 0, w, 1'b0, 1'b0);
      end

      // R1: random tuning words, occasional clears
      tag = "R1";
      for (int i = 0; i < 600; i++) begin
         w = {$urandom, $urandom};
         if (i % 60 == 0) w = w >> ($urandom % 40);
         step((i % 25) == 0, w, ($urandom % 97) == 0, 1'b0);
      end

      // R7: dither with a zero tuning word must move the error
      step(1'b1, '0, 1'b1, 1'b1);
      repeat (3) step(1'b0, '0, 1'b0, 1'b1);
      last_err = q_err;
      track_err = 1'b1;
      repeat (20) step(1'b0, '0, 1'b0, 1'b1);
      track_err = 1'b0;
      chk(err_changes > 0, "R7", longint'(err_changes), 1);

      // R7: dithered random stream stays in amplitude window
      for (int i = 0; i < 200; i++) begin
         w = {$urandom, $urandom};
         step((i % 40) == 0, w, 1'b0, 1'b1);
      end

      // R1: deterministic output resumes once dither is off
      tag = "R1";
      repeat (60) step(1'b0, '0, 1'b0, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule